// File: doc/BRIEF.md
# Differential SAR Conversion Sequencer

This block runs one conversion of a 16-bit successive-approximation converter built around two binary-weighted capacitor arrays, one per side of a differential input. While idle it keeps the converter in the acquisition phase. In that phase the arrays sample the inputs, and the comparator-side terminals are held at ground by the two sampling switches.

A rising edge on the convert input starts a conversion. The sequencer first opens the sampling switches. It then disconnects both arrays from the inputs and walks the search from the most significant bit down to bit 0. On each step it sets one trial bit on the array switch controls, reads the comparator one cycle later, and keeps or drops that bit. Everything runs on the block's own conversion clock.

When the last bit is resolved, the block goes back to acquisition at once. It presents the code in two's complement and lowers the busy flag in the same cycle, so the result always belongs to the most recent sample.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A conversion starts only when `cnv_i` is sampled high by a clock edge after being sampled low by the previous edge. `busy_o` is high in the cycle that follows that edge. Holding `cnv_i` high does not start a further conversion.
- R2: While `busy_o` is low (acquisition), `samp_sw_o` is 1 (sampling switches closed), `in_conn_o` is 1 (array elements on the analog inputs) and `trial_o` is all zeros.
- R3: In the first busy cycle, `samp_sw_o` is 0 while `in_conn_o` is still 1 and `trial_o` is zero. The sampling switches therefore open before the arrays leave the inputs.
- R4: From the second busy cycle onward, `in_conn_o` is 0. In that second busy cycle `trial_o` equals 16'h8000, so the search begins with the MSB.
- R5: `busy_o` stays high for exactly 17 cycles: 1 setup cycle plus 16 bit-decision cycles.
- R6: Each trial bit is set for one cycle. The `cmp_i` value sampled at the end of that cycle decides the bit: 1 (DAC below the held input) keeps it, 0 clears it. The next lower trial bit is set in the same step.
- R7: On the edge where `busy_o` falls, `result_o` takes the resolved search value with its MSB inverted. This gives two's complement with 0 at midscale, so raw 16'h8000 gives 16'h0000. `result_o` does not change while `busy_o` is high.
- R8: A comparator that always reports 1 (input above full scale) gives 16'h7FFF. One that always reports 0 (input below negative full scale) gives 16'h8000.
- R9: A rising edge on `cnv_i` while `busy_o` is high has no effect. The conversion in progress keeps its length and result, and no extra conversion follows.
- R10: Reset (`rst_n` low, asynchronous) forces acquisition, clears `result_o` to 0 and holds `busy_o` low. This also holds when reset arrives in the middle of a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_i | input | 1 | Convert request; a rising edge ends acquisition |
| cmp_i | input | 1 | Comparator decision: 1 when the DAC level is below the held input |
| samp_sw_o | output | 1 | Sampling switches that ground the comparator-side terminals; 1 = closed |
| in_conn_o | output | 1 | Array elements connected to the analog inputs; 1 = connected |
| trial_o | output | 16 | Per-bit array switch controls; 1 = element on reference, 0 = on ground |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | 16 | Last result in two's complement |

## Verification
A behavioural comparator drives `cmp_i` from the live `trial_o` against a target level. Each target's expected code comes from signed subtraction of midscale.

- **Midscale, zero, full scale and alternating-bit targets.** These separate a wrong sign inversion from a wrong keep/clear rule.
- **Pseudo-random targets.** These exercise every bit position in both directions.
- **A stuck-high and a stuck-low comparator.** These cover the saturating codes.
- **Convert edges inside a busy window, and a convert level held high.** These show that neither lengthens the conversion nor adds a result.
- **A reset in the middle of a conversion.** This confirms the result is cleared with no half-finished result left behind.

// File: rtl/sar_conv_pkg.sv
`timescale 1ns/1ps
package sar_conv_pkg;
  // Conversion phases of the sequencer
  typedef enum logic [1:0] {
    PH_ACQ   = 2'd0,
    PH_SETUP = 2'd1,
    PH_BITS  = 2'd2
  } phase_e;
endpackage

// File: rtl/sar_cnv_edge.sv
`timescale 1ns/1ps
// Registers the convert input and flags a low-to-high change.
module sar_cnv_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cnv_i,
  output logic rise_o
);
  logic cnv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnv_q <= 1'b0;
    else        cnv_q <= cnv_i;
  end

  assign rise_o = cnv_i && !cnv_q;
endmodule

// File: rtl/sar_phase_seq.sv
`timescale 1ns/1ps
// Phase sequencer: acquisition -> setup (switches open) -> NBITS decisions.
module sar_phase_seq
  import sar_conv_pkg::*;
#(
  parameter int NBITS = 16,
  localparam int IDXW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rise_i,
  output logic            start_o,
  output logic            last_o,
  output phase_e          phase_o,
  output logic [IDXW-1:0] bit_idx_o
);
  localparam logic [IDXW-1:0] TOP_IDX = IDXW'(NBITS - 1);

  phase_e          phase_q;
  logic [IDXW-1:0] idx_q;

  // A request only counts when idle; during a conversion it is dropped.
  assign start_o   = rise_i && (phase_q == PH_ACQ);
  assign last_o    = (phase_q == PH_BITS) && (idx_q == '0);
  assign phase_o   = phase_q;
  assign bit_idx_o = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ACQ;
      idx_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_ACQ: begin
          if (start_o) phase_q <= PH_SETUP;
        end
        PH_SETUP: begin
          phase_q <= PH_BITS;
          idx_q   <= TOP_IDX;
        end
        PH_BITS: begin
          if (idx_q == '0) phase_q <= PH_ACQ;
          else             idx_q   <= idx_q - IDXW'(1);
        end
        default: phase_q <= PH_ACQ;
      endcase
    end
  end
endmodule

// File: rtl/sar_search_reg.sv
`timescale 1ns/1ps
// Successive-approximation register, trial drive and result capture.
module sar_search_reg
  import sar_conv_pkg::*;
#(
  parameter int NBITS = 16,
  localparam int IDXW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase_i,
  input  logic [IDXW-1:0]  bit_idx_i,
  input  logic             cmp_i,
  input  logic             last_i,
  output logic [NBITS-1:0] trial_o,
  output logic [NBITS-1:0] result_o
);
  localparam logic [NBITS-1:0] MSB_ONE = {1'b1, {(NBITS-1){1'b0}}};

  // Offset-binary search value to two's complement: flip the sign bit.
  function automatic logic [NBITS-1:0] raw_to_twos(input logic [NBITS-1:0] raw);
    logic [NBITS-1:0] r;
    r = raw;
    r[NBITS-1] = ~raw[NBITS-1];
    return r;
  endfunction

  logic [NBITS-1:0] sar_q;
  logic [NBITS-1:0] sar_nxt;

  // Per bit: decide the bit under trial, arm the one below, hold the rest.
  for (genvar g = 0; g < NBITS; g++) begin : g_bit
    assign sar_nxt[g] = (int'(bit_idx_i) == g)     ? cmp_i :
                        (int'(bit_idx_i) == g + 1) ? 1'b1  : sar_q[g];
  end

  assign trial_o = (phase_i == PH_BITS) ? sar_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q    <= '0;
      result_o <= '0;
    end else begin
      if (phase_i == PH_SETUP) sar_q <= MSB_ONE;
      else if (phase_i == PH_BITS) sar_q <= sar_nxt;
      if (last_i) result_o <= raw_to_twos(sar_nxt);
    end
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
`timescale 1ns/1ps
// Top: differential dual-array SAR conversion sequencer.
module sar_conv_ctrl
  import sar_conv_pkg::*;
#(
  parameter int NBITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnv_i,
  input  logic             cmp_i,
  output logic             samp_sw_o,
  output logic             in_conn_o,
  output logic [NBITS-1:0] trial_o,
  output logic             busy_o,
  output logic [NBITS-1:0] result_o
);
  localparam int IDXW = (NBITS > 1) ? $clog2(NBITS) : 1;

  // Internal events, named for the checker
  logic            cnv_rise;
  logic            start_evt;
  logic            done_evt;
  phase_e          phase;
  logic [IDXW-1:0] bit_idx;

  sar_cnv_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnv_i  (cnv_i),
    .rise_o (cnv_rise)
  );

  sar_phase_seq #(.NBITS(NBITS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_i    (cnv_rise),
    .start_o   (start_evt),
    .last_o    (done_evt),
    .phase_o   (phase),
    .bit_idx_o (bit_idx)
  );

  sar_search_reg #(.NBITS(NBITS)) u_sar (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_i   (phase),
    .bit_idx_i (bit_idx),
    .cmp_i     (cmp_i),
    .last_i    (done_evt),
    .trial_o   (trial_o),
    .result_o  (result_o)
  );

  assign busy_o    = (phase != PH_ACQ);
  assign samp_sw_o = (phase == PH_ACQ);
  assign in_conn_o = (phase != PH_BITS);
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for the conversion sequencer.
module sar_conv_ctrl_chk #(
  parameter int NBITS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_evt,
  input logic             done_evt,
  input logic             samp_sw_o,
  input logic             in_conn_o,
  input logic [NBITS-1:0] trial_o,
  input logic             busy_o,
  input logic [NBITS-1:0] result_o
);
  localparam logic [NBITS-1:0] MSB_ONE = {1'b1, {(NBITS-1){1'b0}}};

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy_o);                                             // R1
  AST_ACQ_SWITCHES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (samp_sw_o && in_conn_o && trial_o == '0));            // R2
  AST_SAMP_OPENS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (!samp_sw_o && in_conn_o && trial_o == '0));     // R3
  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_conn_o) |-> (busy_o && trial_o == MSB_ONE));              // R4
  AST_SETUP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |=> !in_conn_o);                                     // R5
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy_o);                                             // R5
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> $stable(result_o));                                     // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_o) && busy_o) |-> !samp_sw_o);                         // R9
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.NBITS(NBITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_evt (start_evt),
  .done_evt  (done_evt),
  .samp_sw_o (samp_sw_o),
  .in_conn_o (in_conn_o),
  .trial_o   (trial_o),
  .busy_o    (busy_o),
  .result_o  (result_o)
);

// File: tb/sar_conv_ctrl_bench.sv
`timescale 1ns/1ps
module sar_conv_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB         = 16;
  localparam int BUSY_CYC   = NB + 1;
  localparam logic [NB-1:0] MSB_ONE = 16'h8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv = 1'b0;
  logic [NB-1:0] tgt = '0;
  logic force_hi = 1'b0;
  logic force_lo = 1'b0;

  logic          samp, conn, busy;
  logic [NB-1:0] trial, result;

  // Behavioural comparator: 1 when the DAC trial level is not above the input
  wire cmp = force_hi ? 1'b1 : force_lo ? 1'b0 : (trial <= tgt);

  sar_conv_ctrl u_sar_conv_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnv_i     (cnv),
    .cmp_i     (cmp),
    .samp_sw_o (samp),
    .in_conn_o (conn),
    .trial_o   (trial),
    .busy_o    (busy),
    .result_o  (result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int n_done = 0;
  int n_sent = 0;
  logic [NB-1:0] expq[$];
  string         reqq[$];
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Expected code: signed distance of the input from midscale, saturated
  function automatic logic [NB-1:0] expect_code(input logic [NB-1:0] v,
                                                input bit hi, input bit lo);
    if (hi) return 16'h7FFF;
    if (lo) return 16'h8000;
    return NB'(int'(v) - 32768);
  endfunction

  // Driver: push the expected item, then raise the convert edge
  task automatic convert(input logic [NB-1:0] v, input bit hi, input bit lo,
                         input string req);
    @(negedge clk);
    tgt = v; force_hi = hi; force_lo = lo;
    expq.push_back(expect_code(v, hi, lo));
    reqq.push_back(req);
    n_sent++;
    cnv = 1'b1;
    @(negedge clk);
    cnv = 1'b0;
    repeat (BUSY_CYC + 3) @(negedge clk);
  endtask

  // Monitor: tracks the busy window and scores each finished result
  logic busy_q = 1'b0;
  int   cnt = 0;
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      busy_q = 1'b0;
      cnt = 0;
    end else begin
      if (busy && !busy_q) begin
        cnt = 1;
        chk(!samp && conn && trial == '0, "R3", "first busy cycle switches",
            {samp, conn, trial}, {2'b01, 16'h0});
      end else if (busy) begin
        cnt++;
        if (cnt == 2)
          chk(trial == MSB_ONE && !conn, "R4", "MSB trial first",
              {conn, trial}, {1'b0, MSB_ONE});
      end
      if (!busy && busy_q) begin
        n_done++;
        chk(cnt == BUSY_CYC, "R5", "busy length", cnt, BUSY_CYC);
        chk(samp && conn && trial == '0, "R2", "acquisition after done",
            {samp, conn, trial}, {2'b11, 16'h0});
        if (expq.size() == 0) begin
          chk(1'b0, "R9", "unexpected extra result", result, 0);
        end else begin
          automatic logic [NB-1:0] e = expq.pop_front();
          automatic string r = reqq.pop_front();
          chk(result == e, r, "result code", result, e);
        end
      end
      busy_q = busy;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [NB-1:0] lfsr;
    int done_before;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(busy == 1'b0, "R10", "busy in reset", busy, 0);
    chk(result == '0, "R10", "result in reset", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(samp && conn && trial == '0, "R2", "idle switches",
        {samp, conn, trial}, {2'b11, 16'h0});
    chk(busy == 1'b0 && result == '0, "R10", "after reset release",
        {busy, result}, 0);

    // R6/R7: directed targets
    convert(16'h8000, 0, 0, "R7");
    convert(16'h0000, 0, 0, "R7");
    convert(16'hFFFF, 0, 0, "R7");
    convert(16'h1234, 0, 0, "R6");
    convert(16'hA5A5, 0, 0, "R6");
    convert(16'h5555, 0, 0, "R6");
    convert(16'h7FFF, 0, 0, "R7");
    convert(16'h8001, 0, 0, "R7");
    // R6: pseudo-random targets
    lfsr = 16'hACE1;
    for (int i = 0; i < 20; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      convert(lfsr, 0, 0, "R6");
    end
    // R8: out-of-range inputs saturate
    convert(16'h0000, 1, 0, "R8");
    convert(16'hFFFF, 0, 1, "R8");

    // R9: convert edges during busy are ignored
    @(negedge clk);
    tgt = 16'h3C3C; force_hi = 0; force_lo = 0;
    expq.push_back(expect_code(16'h3C3C, 0, 0));
    reqq.push_back("R9");
    n_sent++;
    cnv = 1'b1;
    @(negedge clk); cnv = 1'b0;
    repeat (4) @(negedge clk); cnv = 1'b1;
    @(negedge clk); cnv = 1'b0;
    repeat (4) @(negedge clk); cnv = 1'b1;
    @(negedge clk); cnv = 1'b0;
    repeat (BUSY_CYC + 10) @(negedge clk);
    chk(busy == 1'b0, "R9", "no retrigger after busy edges", busy, 0);
    chk(n_done == n_sent, "R9", "result count", n_done, n_sent);

    // R1: a held-high convert level starts only one conversion
    @(negedge clk);
    tgt = 16'h00FF;
    expq.push_back(expect_code(16'h00FF, 0, 0));
    reqq.push_back("R1");
    n_sent++;
    cnv = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R1", "busy after convert edge", busy, 1);
    repeat (BUSY_CYC + 20) @(negedge clk);
    chk(busy == 1'b0, "R1", "held level does not restart", busy, 0);
    chk(n_done == n_sent, "R1", "result count held level", n_done, n_sent);
    cnv = 1'b0;
    @(negedge clk);

    // R10: reset in the middle of a conversion
    done_before = n_done;
    tgt = 16'h4321;
    cnv = 1'b1;
    @(negedge clk); cnv = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(busy == 1'b0, "R10", "busy cleared by reset", busy, 0);
    chk(result == '0, "R10", "result cleared by reset", result, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (BUSY_CYC + 5) @(negedge clk);
    chk(busy == 1'b0 && n_done == done_before, "R10",
        "no result after aborted run", n_done, done_before);
    chk(samp && conn, "R2", "idle after abort", {samp, conn}, 2'b11);

    // One more full conversion after the abort
    convert(16'hC001, 0, 0, "R7");
    chk(expq.size() == 0, "R7", "scoreboard drained", expq.size(), 0);
    finish_run();
  end
endmodule